// File: doc/BRIEF.md
# Gate Driver Output Control Core

This block is the digital control core of a single-channel isolated gate driver. It takes two command inputs, one active high and one active low, and passes each through a synchronizer and a stability filter so that short spikes never reach the power switch. The filtered commands then go through a polarity and interlock decode. The result drives three output-stage enables: a source (turn-on) switch, a sink (turn-off) switch and an active Miller clamp switch.

Four protection sources can force a fixed safe state. The safe state turns the sink and the clamp on and the source off, whatever the commands are. The four sources are: gate-supply undervoltage with hysteresis, over-temperature with hysteresis, a missing control-side supply, and loss of the heartbeat on the link across the isolation barrier. Supply voltage and temperature arrive as digital codes. The clamp comparator arrives as one bit that is high while the monitored gate voltage is below the clamp threshold. All three enables are registered. The active-low synchronous reset puts the outputs in the safe state.

Top module: `gate_drv_ctrl`

## Requirements
- R1: Outside the safe state the source is enabled only while the filtered positive command is 1 and the filtered negative command is 0. The combinations 00, 01 and 11 (written pos,neg) enable the sink instead.
- R2: The source and sink enables are never 1 in the same cycle. Exactly one of them is 1 in every cycle.
- R3: In the safe state the outputs are src_en=0, snk_en=1 and clamp_en=1.
- R4: After reset the block stays in the safe state until sup_code >= SUP_ON. It re-enters the safe state when sup_code < SUP_OFF. For codes between the two thresholds the undervoltage state does not change.
- R5: When a fault clears, the outputs follow the command inputs present at that time. No earlier command is replayed.
- R6: The safe state is forced when temp_code >= TEMP_HOT. It is released only when temp_code < TEMP_COOL.
- R7: While ctl_sup_ok is 0 the outputs stay in the safe state.
- R8: After reset the link counts as lost until the first link_beat pulse. It is declared lost WDOG_CYC cycles after the last pulse, and it recovers on the next pulse. While the link is lost the outputs are in the safe state.
- R9: A command input pulse shorter than DEGLITCH_CYC clock cycles causes no output change. A level held for DEGLITCH_CYC cycles or more is accepted.
- R10: Outside the safe state, clamp_en is 1 only while snk_en is 1 and gate_low is 1.
- R11: During reset the outputs are src_en=0, snk_en=1 and clamp_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_pos | input | 1 | Command input, active high, asynchronous |
| in_neg | input | 1 | Command input, active low, asynchronous |
| sup_code | input | SUP_W | Gate-supply voltage code |
| temp_code | input | TEMP_W | Die temperature code |
| ctl_sup_ok | input | 1 | Control-side supply present, asynchronous |
| link_beat | input | 1 | One-cycle heartbeat from the isolation link |
| gate_low | input | 1 | Clamp comparator: gate voltage below the clamp threshold |
| src_en | output | 1 | Source switch enable |
| snk_en | output | 1 | Sink switch enable |
| clamp_en | output | 1 | Miller clamp switch enable |

## Verification
The assertions take several things for granted. The codes and gate_low are synchronous to clk, and link_beat is a pulse sampled in the clock domain. Only the two commands and ctl_sup_ok may change at any time. The bench drives every input on the falling edge and never changes the codes and the commands in the same cycle. After each stimulus it waits long enough to cover the synchronizer and filter delay before it samples. Heartbeats arrive every 16 cycles, well inside the watchdog window, except in the scenario that withholds them on purpose.

// File: rtl/gdc_pkg.sv
// Package: shared types and constants for the gate driver control core.
// Assumes: nothing; pure declarations.
package gdc_pkg;
    // Output enable bundle driven toward the analog stages.
    typedef struct packed {
        logic src;
        logic snk;
        logic clamp;
    } drv_t;

    // Enables that make up the protective state.
    localparam drv_t DRV_SAFE = '{src: 1'b0, snk: 1'b1, clamp: 1'b1};

    // Minimum synchronizer depth for asynchronous inputs.
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gdc_deglitch.sv
// Module: gdc_deglitch
// Synchronizes one asynchronous level into clk, then accepts a new level
// only after it has been stable for DEGLITCH_CYC consecutive cycles.
// Assumes: STAGES >= 2, DEGLITCH_CYC >= 1. Output resets to 0.
module gdc_deglitch #(
    parameter int STAGES       = 2,
    parameter int DEGLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CNT_W = $clog2(DEGLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEGLITCH_CYC - 1);

    logic [STAGES-1:0] sync_q;
    logic              sync_lvl;
    logic [CNT_W-1:0]  cnt_q;
    logic              filt_q;

    assign sync_lvl = sync_q[STAGES-1];
    assign filt     = filt_q;

    // Purpose: shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], raw};
    end

    // Purpose: count stable cycles of a differing level and commit it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (sync_lvl != filt_q) begin
            if (cnt_q == LAST) begin
                filt_q <= sync_lvl;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // R9: a committed change always takes the synchronized level.
    a_r9_filt_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> filt_q == $past(sync_lvl));
endmodule

// File: rtl/gdc_hyst.sv
// Module: gdc_hyst
// Two-threshold comparator with memory on a digital code. With TRIP_HIGH=1
// the flag sets at code >= TRIP_TH and clears at code < CLR_TH. With
// TRIP_HIGH=0 it sets at code < TRIP_TH and clears at code >= CLR_TH.
// Assumes: thresholds are ordered so the two regions do not overlap.
module gdc_hyst #(
    parameter int CODE_W      = 10,
    parameter int TRIP_TH     = 592,
    parameter int CLR_TH      = 620,
    parameter bit TRIP_HIGH   = 1'b0,
    parameter bit RST_TRIPPED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tripped
);
    localparam logic [CODE_W-1:0] TRIP_V = CODE_W'(TRIP_TH);
    localparam logic [CODE_W-1:0] CLR_V  = CODE_W'(CLR_TH);

    logic trip_hit;
    logic clr_hit;
    logic flag_q;

    assign tripped = flag_q;

    generate
        if (TRIP_HIGH) begin : g_high
            // Purpose: over-limit detection (for example temperature).
            always_comb begin
                trip_hit = (code >= TRIP_V);
                clr_hit  = (code <  CLR_V);
            end
            // R6: the flag sets only on a code at or above the trip level.
            a_r6_set_at_hot: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q) |-> $past(code) >= TRIP_V);
            // R6: the flag clears only on a code below the release level.
            a_r6_clear_when_cool: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_q) |-> $past(code) < CLR_V);
        end else begin : g_low
            // Purpose: under-limit detection (for example supply voltage).
            always_comb begin
                trip_hit = (code <  TRIP_V);
                clr_hit  = (code >= CLR_V);
            end
            // R4: the flag sets only on a code below the turn-off level.
            a_r4_set_below_off: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q) |-> $past(code) < TRIP_V);
            // R4: the flag clears only on a code at or above the turn-on level.
            a_r4_clear_above_on: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flag_q) |-> $past(code) >= CLR_V);
        end
    endgenerate

    // Purpose: hold the flag between thresholds, move it outside them.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= RST_TRIPPED;
        else if (!flag_q && trip_hit) flag_q <= 1'b1;
        else if (flag_q && clr_hit)   flag_q <= 1'b0;
    end
endmodule

// File: rtl/gdc_watchdog.sv
// Module: gdc_watchdog
// Declares the link lost when no heartbeat has arrived for WDOG_CYC cycles;
// the next heartbeat restores it. Starts in the lost state after reset.
// Assumes: beat is synchronous to clk; WDOG_CYC >= 2.
module gdc_watchdog #(
    parameter int WDOG_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    output logic lost
);
    localparam int CNT_W = $clog2(WDOG_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WDOG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             lost_q;

    assign lost = lost_q;

    // Purpose: restart on a heartbeat, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lost_q <= 1'b1;
        end else if (beat) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            lost_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: a heartbeat always restores the link in the next cycle.
    a_r8_beat_restores: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> !lost_q);
    // R8: the link is never declared lost in the cycle after a heartbeat.
    a_r8_no_loss_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_q) |-> !$past(beat));
endmodule

// File: rtl/gate_drv_ctrl.sv
// Module: gate_drv_ctrl
// Control core of a single-channel gate driver. It filters the two command
// inputs, decodes polarity with an interlock, merges four fault sources into
// a safe state and registers the source, sink and clamp enables.
// Assumes: codes, gate_low and link_beat are synchronous to clk; in_pos,
// in_neg and ctl_sup_ok may be asynchronous.
module gate_drv_ctrl #(
    parameter int SUP_W        = 10,
    parameter int TEMP_W       = 8,
    parameter int SUP_ON       = 620,
    parameter int SUP_OFF      = 592,
    parameter int TEMP_HOT     = 170,
    parameter int TEMP_COOL    = 150,
    parameter int DEGLITCH_CYC = 4,
    parameter int WDOG_CYC     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_pos,
    input  logic              in_neg,
    input  logic [SUP_W-1:0]  sup_code,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              ctl_sup_ok,
    input  logic              link_beat,
    input  logic              gate_low,
    output logic              src_en,
    output logic              snk_en,
    output logic              clamp_en
);
    import gdc_pkg::*;

    localparam int N_CMD = 2;

    logic [N_CMD-1:0]       raw_cmd;
    logic [N_CMD-1:0]       filt_cmd;
    logic [SYNC_STAGES-1:0] ok_sync_q;
    logic                   uv_trip;
    logic                   hot_trip;
    logic                   link_lost;
    logic                   safe_now;
    logic                   turn_on;
    drv_t                   drv_next;
    drv_t                   drv_q;

    assign raw_cmd = {in_neg, in_pos};

    generate
        for (genvar i = 0; i < N_CMD; i++) begin : g_cmd
            gdc_deglitch #(
                .STAGES       (SYNC_STAGES),
                .DEGLITCH_CYC (DEGLITCH_CYC)
            ) u_dg (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (raw_cmd[i]),
                .filt  (filt_cmd[i])
            );
        end
    endgenerate

    gdc_hyst #(
        .CODE_W (SUP_W), .TRIP_TH (SUP_OFF), .CLR_TH (SUP_ON),
        .TRIP_HIGH (1'b0), .RST_TRIPPED (1'b1)
    ) u_uv (
        .clk (clk), .rst_n (rst_n), .code (sup_code), .tripped (uv_trip)
    );

    gdc_hyst #(
        .CODE_W (TEMP_W), .TRIP_TH (TEMP_HOT), .CLR_TH (TEMP_COOL),
        .TRIP_HIGH (1'b1), .RST_TRIPPED (1'b0)
    ) u_ot (
        .clk (clk), .rst_n (rst_n), .code (temp_code), .tripped (hot_trip)
    );

    gdc_watchdog #(
        .WDOG_CYC (WDOG_CYC)
    ) u_wd (
        .clk (clk), .rst_n (rst_n), .beat (link_beat), .lost (link_lost)
    );

    // Purpose: bring the control-side supply status into clk.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_sync_q <= '0;
        else        ok_sync_q <= {ok_sync_q[SYNC_STAGES-2:0], ctl_sup_ok};
    end

    // Purpose: merge faults and decode the interlocked command.
    always_comb begin
        safe_now = uv_trip | hot_trip | link_lost | ~ok_sync_q[SYNC_STAGES-1];
        turn_on  = filt_cmd[0] & ~filt_cmd[1];
        if (safe_now) begin
            drv_next = DRV_SAFE;
        end else begin
            drv_next.src   = turn_on;
            drv_next.snk   = ~turn_on;
            drv_next.clamp = ~turn_on & gate_low;
        end
    end

    // Purpose: register the enables so the analog stages see clean levels.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= DRV_SAFE;
        else        drv_q <= drv_next;
    end

    assign src_en   = drv_q.src;
    assign snk_en   = drv_q.snk;
    assign clamp_en = drv_q.clamp;

    // R2: source and sink are never enabled together.
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_en && snk_en));
    // R2: one of source and sink is always enabled.
    a_r2_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        src_en || snk_en);
    // R3 R4: undervoltage leads to the safe enables one cycle later.
    a_r3_uv_safe: assert property (@(posedge clk) disable iff (!rst_n)
        uv_trip |=> (!src_en && snk_en && clamp_en));
    // R3 R8: a lost link leads to the safe enables one cycle later.
    a_r8_link_safe: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost |=> (!src_en && snk_en && clamp_en));
    // R1: the source turns on only for the filtered 1,0 command.
    a_r1_src_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_en) |-> $past(filt_cmd[0] && !filt_cmd[1]));
    // R10: the clamp is never on unless the sink is on.
    a_r10_clamp_with_sink: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_en |-> snk_en);
endmodule

// File: tb/tb_gate_drv_ctrl.sv
module tb_gate_drv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SUP_ON     = 620;
    localparam int SUP_OFF    = 592;
    localparam int TEMP_HOT   = 170;
    localparam int TEMP_COOL  = 150;
    localparam int DG         = 4;
    localparam int WD         = 64;
    localparam int SETTLE     = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_pos = 1'b0, in_neg = 1'b0;
    logic [9:0] sup_code = 10'd0;
    logic [7:0] temp_code = 8'd25;
    logic       ctl_sup_ok = 1'b0;
    logic       link_beat = 1'b0;
    logic       gate_low = 1'b0;
    logic       beat_on = 1'b0;
    logic       src_en, snk_en, clamp_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_drv_ctrl dut (
        .clk (clk), .rst_n (rst_n), .in_pos (in_pos), .in_neg (in_neg),
        .sup_code (sup_code), .temp_code (temp_code), .ctl_sup_ok (ctl_sup_ok),
        .link_beat (link_beat), .gate_low (gate_low),
        .src_en (src_en), .snk_en (snk_en), .clamp_en (clamp_en)
    );

    // Heartbeat: one-cycle pulse every 16 cycles while enabled.
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 16;
            link_beat = beat_on && (c == 0);
        end
    end

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {src_en, snk_en, clamp_en};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {src,snk,clamp} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // R11 R3: reset state.
    task automatic t_reset();
        rst_n = 1'b0; settle(3);
        chk("R11 reset", 3'b011);
        rst_n = 1'b1; settle(SETTLE);
        chk("R4 held safe before supply rises", 3'b011);
    endtask

    // R4 R8 R7: bring all conditions good; hysteresis between thresholds.
    task automatic t_uv();
        sup_code = 10'(SUP_OFF + 5); ctl_sup_ok = 1'b1; beat_on = 1'b1;
        settle(SETTLE + 20);
        chk("R4 between thresholds after reset stays safe", 3'b011);
        sup_code = 10'(SUP_ON); settle(SETTLE);
        chk("R4 at turn-on level released", 3'b010);
        sup_code = 10'(SUP_OFF); settle(SETTLE);
        chk("R4 at turn-off level stays active", 3'b010);
        sup_code = 10'(SUP_OFF - 1); settle(SETTLE);
        chk("R4 below turn-off safe", 3'b011);
        sup_code = 10'(SUP_ON - 1); settle(SETTLE);
        chk("R4 below turn-on still safe", 3'b011);
        in_pos = 1'b1; settle(SETTLE);
        chk("R3 command ignored in safe state", 3'b011);
        sup_code = 10'(SUP_ON + 10); settle(SETTLE);
        chk("R5 recovery follows present command", 3'b100);
        in_pos = 1'b0; settle(SETTLE);
    endtask

    // R1: truth table, gate_low=0 so clamp shows 0 outside safe.
    task automatic t_truth();
        for (int k = 0; k < 4; k++) begin
            in_pos = k[0]; in_neg = k[1]; settle(SETTLE);
            chk("R1 truth table", (k == 1) ? 3'b100 : 3'b010);
        end
        in_pos = 1'b0; in_neg = 1'b0; settle(SETTLE);
    endtask

    // R10: clamp follows the comparator only while sinking.
    task automatic t_clamp();
        gate_low = 1'b1; settle(4);
        chk("R10 clamp on when sinking and gate low", 3'b011);
        in_pos = 1'b1; settle(SETTLE);
        chk("R10 clamp off while sourcing", 3'b100);
        in_pos = 1'b0; settle(SETTLE);
        gate_low = 1'b0; settle(4);
        chk("R10 clamp off when gate above threshold", 3'b010);
    endtask

    // R6: thermal hysteresis.
    task automatic t_thermal();
        temp_code = 8'(TEMP_HOT - 1); settle(4);
        chk("R6 below hot active", 3'b010);
        temp_code = 8'(TEMP_HOT); settle(4);
        chk("R6 hot forces safe", 3'b011);
        temp_code = 8'(TEMP_COOL); settle(4);
        chk("R6 at release level still safe", 3'b011);
        temp_code = 8'(TEMP_COOL - 1); settle(4);
        chk("R6 cool releases", 3'b010);
    endtask

    // R7: control-side supply.
    task automatic t_ctl_sup();
        ctl_sup_ok = 1'b0; settle(6);
        chk("R7 supply absent safe", 3'b011);
        ctl_sup_ok = 1'b1; settle(6);
        chk("R7 supply back active", 3'b010);
    endtask

    // R8: watchdog loss and recovery.
    task automatic t_wdog();
        beat_on = 1'b0; settle(WD / 2);
        chk("R8 inside window active", 3'b010);
        settle(WD + 10);
        chk("R8 link lost safe", 3'b011);
        beat_on = 1'b1; settle(20);
        chk("R8 recovers on heartbeat", 3'b010);
    endtask

    // R9: deglitch.
    task automatic t_deglitch();
        bit seen;
        seen = 1'b0;
        @(negedge clk) in_pos = 1'b1;
        repeat (DG - 1) @(negedge clk);
        in_pos = 1'b0;
        repeat (SETTLE) begin
            @(negedge clk);
            if (src_en) seen = 1'b1;
        end
        n_cmp++;
        if (seen) begin
            n_bad++;
            $display("FAIL R9 short pulse: src seen %b expected %b", seen, 1'b0);
        end
        seen = 1'b0;
        @(negedge clk) in_pos = 1'b1;
        repeat (DG) @(negedge clk);
        in_pos = 1'b0;
        repeat (SETTLE) begin
            @(negedge clk);
            if (src_en) seen = 1'b1;
        end
        n_cmp++;
        if (!seen) begin
            n_bad++;
            $display("FAIL R9 full pulse: src seen %b expected %b", seen, 1'b1);
        end
        chk("R9 returns to sink", 3'b010);
    endtask

    initial begin
        t_reset();
        t_uv();
        t_truth();
        t_clamp();
        t_thermal();
        t_ctl_sup();
        t_wdog();
        t_deglitch();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, got %0d expected %0d", 0, 1);
            finish_run();
        end
    end
endmodule